// File: doc/BRIEF.md
# Segment Display Memory and Command Decoder

This block sits behind a serial slave front end that has already framed the bus traffic into bytes. It turns those bytes into either control settings or display data. Each byte comes with a flag marking it as the first byte after the slave address, which makes it the command byte. A separate pulse marks the start of a new transfer. A command byte either loads the display address pointer, updates one of three configuration registers, or matches nothing and is dropped.

After a pointer command, the remaining bytes of the transfer go into a 22-byte display memory, and the pointer advances after each byte. After any other command byte, the rest of the transfer is discarded. Reads return the byte at the pointer, and the pointer moves on only when the master acknowledges. The pointer wraps from the last address back to zero, both on writes and on reads.

Each memory byte carries two neighbouring segments across four commons. The segment drive logic selects one common and receives the full row of segment bits for it.

Top module: `sdc_core`

## Requirements
- R1: After reset the block shows the following. Bias is 1/3 (`bias_half`=0), frame rate is 80 Hz (`frame_fast`=0), and the oscillator and display are off. Blink is off (`blink_sel`=00). The voltage-adjust fields are `vadj_de`=1, `vadj_ve`=1 and `vadj_da`=0000, with `follower_en`=0. The pointer is 0, and every display memory byte reads 0.
- R2: A command byte 000aaaaa with aaaaa in 0x00..0x15 loads the pointer with aaaaa. Each later non-command byte of that transfer is stored at the pointer, and the pointer then steps by one.
- R3: The pointer steps from 0x15 to 0x00. This holds for data writes and for acknowledged reads.
- R4: A command byte 100F SE0M sets the following, one cycle after the byte: `bias_half`=M (bit 0), `frame_fast`=F (bit 4), `osc_en`=S (bit 3) and `disp_en`=S AND E (E is bit 2).
- R5: A command byte 110000bb sets `blink_sel`=bb. The codes are 00 off, 01 2 Hz, 10 1 Hz and 11 0.5 Hz.
- R6: A command byte 01 D V dddd sets `vadj_de`=D (bit 5), `vadj_ve`=V (bit 4) and `vadj_da`=dddd (bits 3:0). `follower_en` is 1 exactly when dddd is nonzero and (D,V) is not (1,0).
- R7: A command byte that matches none of the patterns above changes no setting, no memory byte and not the pointer. A pointer command with an address above 0x15 counts as such a byte. The bytes after it in the same transfer are ignored.
- R8: After a mode, blink or voltage-adjust command byte, every later non-command byte of that transfer leaves the memory and the pointer unchanged.
- R9: `rd_data` always shows the memory byte at the pointer. An ACK (`rd_ack_valid`=1, `rd_ack_ok`=1) steps the pointer. A NACK (`rd_ack_ok`=0) leaves it unchanged.
- R10: For common c=`com_sel`, `seg_row[2k]` is bit c of byte k (the even segment, lower nibble). `seg_row[2k+1]` is bit 4+c of byte k (the odd segment, upper nibble).
- R11: A non-command byte that arrives after `xfer_start` and before any command byte is ignored. A byte flagged as a command is always decoded as one, even in the middle of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start | input | 1 | Pulse: a new transfer has begun |
| in_valid | input | 1 | A received byte is presented this cycle |
| in_first | input | 1 | The byte is the first after the slave address (a command byte) |
| in_data | input | 8 | Received byte |
| rd_ack_valid | input | 1 | The master has answered a read byte |
| rd_ack_ok | input | 1 | 1 = ACK, 0 = NACK |
| rd_data | output | 8 | Memory byte at the pointer |
| com_sel | input | 2 | Common chosen for the segment row |
| seg_row | output | SEGS | Segment bits for the chosen common |
| bias_half | output | 1 | 1 = 1/2 bias, 0 = 1/3 bias |
| frame_fast | output | 1 | 1 = 160 Hz frame, 0 = 80 Hz frame |
| osc_en | output | 1 | Oscillator enable |
| disp_en | output | 1 | Display enable |
| blink_sel | output | 2 | Blink rate code |
| vadj_de | output | 1 | Shared-pin select bit |
| vadj_ve | output | 1 | Internal voltage adjust enable |
| vadj_da | output | 4 | Voltage adjust step |
| follower_en | output | 1 | Voltage follower enable |

## Verification
The bench uses the default SEGS=44. That gives 22 memory bytes and a 5-bit pointer, so a write burst of 24 bytes crosses the 0x15-to-0x00 wrap, and 0x15 against 0x16 tests the last legal pointer command against the first illegal one. With four commons, every common of `seg_row` can be compared against a model memory after each step. The reference model is built from the byte patterns alone. It covers mode, blink and voltage-adjust codes, undefined bytes, trailing bytes after control commands, and ACK against NACK reads.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  localparam int COMS = 4;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_PTR,
    OP_MODE,
    OP_BLINK,
    OP_VADJ
  } op_t;

  typedef enum logic [1:0] {
    ST_CMD,
    ST_DATA,
    ST_SKIP
  } rx_state_t;

  typedef struct packed {
    logic frame_fast;
    logic sel_s;
    logic sel_e;
    logic bias_half;
  } mode_t;

  typedef struct packed {
    logic       de;
    logic       ve;
    logic [3:0] da;
  } vadj_t;

endpackage

// File: rtl/sdc_op_decode.sv
module sdc_op_decode
  import sdc_pkg::*;
#(
  parameter int DEPTH = 22
) (
  input  logic [7:0] byte_i,
  output op_t        op_o
);

  localparam logic [4:0] LAST_ADDR = 5'(DEPTH - 1);

  always_comb begin
    op_o = OP_NONE;
    if (byte_i[7:5] == 3'b000) begin
      if (byte_i[4:0] <= LAST_ADDR) op_o = OP_PTR;
    end else if (byte_i[7:5] == 3'b100 && byte_i[1] == 1'b0) begin
      op_o = OP_MODE;
    end else if (byte_i[7:2] == 6'b110000) begin
      op_o = OP_BLINK;
    end else if (byte_i[7:6] == 2'b01) begin
      op_o = OP_VADJ;
    end
  end

endmodule

// File: rtl/sdc_cfg_regs.sv
module sdc_cfg_regs
  import sdc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_en,
  input  op_t        op_i,
  input  logic [7:0] byte_i,
  output mode_t      mode_o,
  output logic [1:0] blink_o,
  output vadj_t      vadj_o
);

  mode_t      mode_q, mode_d;
  logic [1:0] blink_q, blink_d;
  vadj_t      vadj_q, vadj_d;

  always_comb begin
    mode_d  = mode_q;
    blink_d = blink_q;
    vadj_d  = vadj_q;
    if (cmd_en) begin
      unique case (op_i)
        OP_MODE: begin
          mode_d.frame_fast = byte_i[4];
          mode_d.sel_s      = byte_i[3];
          mode_d.sel_e      = byte_i[2];
          mode_d.bias_half  = byte_i[0];
        end
        OP_BLINK: blink_d = byte_i[1:0];
        OP_VADJ: begin
          vadj_d.de = byte_i[5];
          vadj_d.ve = byte_i[4];
          vadj_d.da = byte_i[3:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      blink_q <= 2'b00;
      vadj_q  <= '{de: 1'b1, ve: 1'b1, da: 4'h0};
    end else begin
      mode_q  <= mode_d;
      blink_q <= blink_d;
      vadj_q  <= vadj_d;
    end
  end

  assign mode_o  = mode_q;
  assign blink_o = blink_q;
  assign vadj_o  = vadj_q;

  // R7
  cfg_undef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && op_i == OP_NONE) |=> $stable({mode_q, blink_q, vadj_q}));

endmodule

// File: rtl/sdc_addr_ptr.sv
module sdc_addr_ptr #(
  parameter int DEPTH = 22,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_i,
  output logic [AW-1:0] ptr_o
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (load_i) begin
      ptr_d = load_val_i;
    end else if (step_i) begin
      ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  // R3
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= LAST);

  // R3
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && ptr_q == LAST) |=> ptr_q == '0);

endmodule

// File: rtl/sdc_disp_mem.sv
module sdc_disp_mem
  import sdc_pkg::*;
#(
  parameter int DEPTH = 22,
  parameter int AW    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [7:0]        rd_data_o,
  input  logic [1:0]        com_sel_i,
  output logic [2*DEPTH-1:0] row_o
);

  logic [2*COMS-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  for (genvar k = 0; k < DEPTH; k++) begin : g_pair
    assign row_o[2*k]   = mem_q[k][{1'b0, com_sel_i}];
    assign row_o[2*k+1] = mem_q[k][{1'b1, com_sel_i}];
  end

  // R2
  mem_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> mem_q[$past(wr_addr_i)] == $past(wr_data_i));

endmodule

// File: rtl/sdc_core.sv
module sdc_core
  import sdc_pkg::*;
#(
  parameter int SEGS = 44
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            xfer_start,
  input  logic            in_valid,
  input  logic            in_first,
  input  logic [7:0]      in_data,
  input  logic            rd_ack_valid,
  input  logic            rd_ack_ok,
  output logic [7:0]      rd_data,
  input  logic [1:0]      com_sel,
  output logic [SEGS-1:0] seg_row,
  output logic            bias_half,
  output logic            frame_fast,
  output logic            osc_en,
  output logic            disp_en,
  output logic [1:0]      blink_sel,
  output logic            vadj_de,
  output logic            vadj_ve,
  output logic [3:0]      vadj_da,
  output logic            follower_en
);

  localparam int DEPTH = SEGS / 2;
  localparam int AW    = $clog2(DEPTH);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  op_t       op;
  rx_state_t state_q, state_d;
  logic      cmd_byte, data_byte, ack_step;
  logic      ptr_load, ptr_step;
  logic [AW-1:0] ptr;
  mode_t     mode;
  vadj_t     vadj;

  sdc_op_decode #(.DEPTH(DEPTH)) u_dec (
    .byte_i (in_data),
    .op_o   (op)
  );

  assign cmd_byte  = in_valid && in_first;
  assign data_byte = in_valid && !in_first && (state_q == ST_DATA);
  assign ack_step  = rd_ack_valid && rd_ack_ok && !in_valid;
  assign ptr_load  = cmd_byte && (op == OP_PTR);
  assign ptr_step  = data_byte || ack_step;

  always_comb begin
    state_d = state_q;
    if (xfer_start) state_d = ST_CMD;
    if (cmd_byte)   state_d = (op == OP_PTR) ? ST_DATA : ST_SKIP;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) state_q <= ST_CMD;
    else          state_q <= state_d;
  end

  sdc_addr_ptr #(.DEPTH(DEPTH), .AW(AW)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .load_i     (ptr_load),
    .load_val_i (in_data[AW-1:0]),
    .step_i     (ptr_step),
    .ptr_o      (ptr)
  );

  sdc_disp_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_en_i   (data_byte),
    .wr_addr_i (ptr),
    .wr_data_i (in_data),
    .rd_addr_i (ptr),
    .rd_data_o (rd_data),
    .com_sel_i (com_sel),
    .row_o     (seg_row)
  );

  sdc_cfg_regs u_cfg (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .cmd_en  (cmd_byte),
    .op_i    (op),
    .byte_i  (in_data),
    .mode_o  (mode),
    .blink_o (blink_sel),
    .vadj_o  (vadj)
  );

  assign bias_half   = mode.bias_half;
  assign frame_fast  = mode.frame_fast;
  assign osc_en      = mode.sel_s;
  assign disp_en     = mode.sel_s && mode.sel_e;
  assign vadj_de     = vadj.de;
  assign vadj_ve     = vadj.ve;
  assign vadj_da     = vadj.da;
  assign follower_en = (vadj.da != 4'h0) && !(vadj.de && !vadj.ve);

  // R8
  skip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (in_valid && !in_first && state_q != ST_DATA) |=> $stable(ptr));

  // R9
  nack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_ack_valid && !rd_ack_ok && !in_valid) |=> $stable(ptr));

endmodule

// File: tb/tb_sdc_core.sv
`timescale 1ns/1ps
module tb_sdc_core;

  localparam int SEGS  = 44;
  localparam int DEPTH = SEGS / 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, xfer_start, in_valid, in_first, rd_ack_valid, rd_ack_ok;
  logic [7:0] in_data, rd_data;
  logic [1:0] com_sel, blink_sel;
  logic [SEGS-1:0] seg_row;
  logic bias_half, frame_fast, osc_en, disp_en, vadj_de, vadj_ve, follower_en;
  logic [3:0] vadj_da;

  sdc_core #(.SEGS(SEGS)) dut (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .in_valid(in_valid),
    .in_first(in_first), .in_data(in_data), .rd_ack_valid(rd_ack_valid),
    .rd_ack_ok(rd_ack_ok), .rd_data(rd_data), .com_sel(com_sel), .seg_row(seg_row),
    .bias_half(bias_half), .frame_fast(frame_fast), .osc_en(osc_en), .disp_en(disp_en),
    .blink_sel(blink_sel), .vadj_de(vadj_de), .vadj_ve(vadj_ve), .vadj_da(vadj_da),
    .follower_en(follower_en)
  );

  // scoreboard queues: kind 0 = rd_data, 1 = settings, 2 = segment row
  int          q_kind[$];
  int          q_idx[$];
  logic [63:0] q_exp[$];
  string       q_req[$];
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  event sample_ev;

  // reference model
  logic [7:0] m_mem [DEPTH];
  int   m_ptr, m_st;
  logic m_f, m_s, m_e, m_m0, m_de, m_ve;
  logic [1:0] m_bk;
  logic [3:0] m_da;

  function automatic logic [63:0] observe(int kind);
    if (kind == 0) return 64'(rd_data);
    if (kind == 1) return 64'({bias_half, frame_fast, osc_en, disp_en, blink_sel,
                               vadj_de, vadj_ve, vadj_da, follower_en});
    return 64'(seg_row);
  endfunction

  initial begin : monitor
    forever begin
      @(sample_ev);
      while (q_kind.size() > 0) begin
        int k; int ix; logic [63:0] ex; string rq; logic [63:0] act;
        k = q_kind.pop_front(); ix = q_idx.pop_front();
        ex = q_exp.pop_front(); rq = q_req.pop_front();
        if (k == 2) begin
          com_sel = ix[1:0];
          #0.5;
        end
        act = observe(k);
        n_run++;
        if (act !== ex) begin
          n_fail++;
          $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h", rq, k, ix, act, ex);
        end
      end
    end
  end

  task automatic push(int kind, int idx, logic [63:0] ex, string rq);
    q_kind.push_back(kind); q_idx.push_back(idx);
    q_exp.push_back(ex); q_req.push_back(rq);
  endtask

  task automatic check_all(string rq);
    logic [63:0] row;
    push(0, 0, 64'(m_mem[m_ptr]), rq);
    push(1, 0, 64'({m_m0, m_f, m_s, m_s & m_e, m_bk, m_de, m_ve, m_da,
                    (m_da != 4'h0) && !(m_de && !m_ve)}), rq);
    for (int c = 0; c < 4; c++) begin
      row = '0;
      for (int k = 0; k < DEPTH; k++) begin
        row[2*k]   = m_mem[k][c];
        row[2*k+1] = m_mem[k][4+c];
      end
      push(2, c, row, {rq, " R10"});
    end
    -> sample_ev;
    wait (q_kind.size() == 0);
    #0.5;
  endtask

  function automatic void step_ptr();
    m_ptr = (m_ptr == DEPTH - 1) ? 0 : m_ptr + 1;
  endfunction

  task automatic start_xfer();
    xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
    m_st = 0;
  endtask

  task automatic send_byte(logic [7:0] d, logic first);
    in_valid = 1'b1; in_data = d; in_first = first;
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0;
    if (first) begin
      if (d[7:5] == 3'b000 && d[4:0] <= 5'(DEPTH - 1)) begin
        m_ptr = int'(d[4:0]); m_st = 1;
      end else if (d[7:5] == 3'b100 && !d[1]) begin
        m_f = d[4]; m_s = d[3]; m_e = d[2]; m_m0 = d[0]; m_st = 2;
      end else if (d[7:2] == 6'b110000) begin
        m_bk = d[1:0]; m_st = 2;
      end else if (d[7:6] == 2'b01) begin
        m_de = d[5]; m_ve = d[4]; m_da = d[3:0]; m_st = 2;
      end else begin
        m_st = 2;
      end
    end else if (m_st == 1) begin
      m_mem[m_ptr] = d;
      step_ptr();
    end
  endtask

  task automatic read_ack(logic ok);
    rd_ack_valid = 1'b1; rd_ack_ok = ok;
    @(negedge clk);
    rd_ack_valid = 1'b0;
    if (ok) step_ptr();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : driver
    rst_n = 1'b0; xfer_start = 1'b0; in_valid = 1'b0; in_first = 1'b0;
    in_data = 8'h00; rd_ack_valid = 1'b0; rd_ack_ok = 1'b0; com_sel = 2'd0;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'h00;
    m_ptr = 0; m_st = 0; m_f = 0; m_s = 0; m_e = 0; m_m0 = 0;
    m_bk = 2'b00; m_de = 1; m_ve = 1; m_da = 4'h0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1 reset");

    // R2 R3: burst of 24 bytes from 0 wraps past 0x15
    start_xfer();
    send_byte(8'h00, 1'b1);
    for (int i = 0; i < DEPTH + 2; i++) send_byte(8'(i * 37 + 11), 1'b0);
    check_all("R2 R3 burst write wrap");

    // R3: start at last address
    start_xfer();
    send_byte(8'h15, 1'b1);
    send_byte(8'hA5, 1'b0);
    send_byte(8'h5A, 1'b0);
    check_all("R3 write at 0x15 then 0x00");

    // R4 R8: mode commands with trailing bytes
    start_xfer();
    send_byte(8'h9D, 1'b1);
    send_byte(8'hFF, 1'b0);
    send_byte(8'h01, 1'b0);
    check_all("R4 R8 mode 9D trailing ignored");
    start_xfer(); send_byte(8'h94, 1'b1);
    check_all("R4 mode 94 osc off");
    start_xfer(); send_byte(8'h88, 1'b1);
    check_all("R4 mode 88 osc on display off");

    // R5 blink codes
    start_xfer(); send_byte(8'hC1, 1'b1); send_byte(8'h33, 1'b0);
    check_all("R5 R8 blink 01");
    start_xfer(); send_byte(8'hC2, 1'b1);
    check_all("R5 blink 10");
    start_xfer(); send_byte(8'hC3, 1'b1);
    check_all("R5 blink 11");

    // R6 voltage adjust
    start_xfer(); send_byte(8'h65, 1'b1);
    check_all("R6 DE=1 VE=0 follower off");
    start_xfer(); send_byte(8'h55, 1'b1); send_byte(8'h77, 1'b0);
    check_all("R6 R8 DE=0 VE=1 follower on");
    start_xfer(); send_byte(8'h70, 1'b1);
    check_all("R6 DA=0 follower off");
    start_xfer(); send_byte(8'h7F, 1'b1);
    check_all("R6 DE=1 VE=1 follower on");

    // R7 undefined bytes
    start_xfer(); send_byte(8'hC4, 1'b1); send_byte(8'h12, 1'b0);
    check_all("R7 C4 undefined");
    start_xfer(); send_byte(8'h16, 1'b1); send_byte(8'h99, 1'b0);
    check_all("R7 pointer 0x16 undefined");
    start_xfer(); send_byte(8'h82, 1'b1); send_byte(8'h44, 1'b0);
    check_all("R7 82 undefined");
    start_xfer(); send_byte(8'h20, 1'b1);
    send_byte(8'hA3, 1'b1); send_byte(8'hE7, 1'b1);
    check_all("R7 20 A3 E7 undefined");

    // R11 data before any command, then a command mid-transfer
    start_xfer(); send_byte(8'hEE, 1'b0);
    check_all("R11 byte before command ignored");
    start_xfer(); send_byte(8'hC0, 1'b1); send_byte(8'h07, 1'b1);
    send_byte(8'h3C, 1'b0);
    check_all("R11 command flag mid-transfer");

    // R9 R3 reads
    start_xfer(); send_byte(8'h14, 1'b1);
    start_xfer();
    check_all("R9 read at 0x14");
    read_ack(1'b1);
    check_all("R9 ACK to 0x15");
    read_ack(1'b0);
    check_all("R9 NACK holds");
    read_ack(1'b1);
    check_all("R9 R3 ACK wraps to 0x00");
    read_ack(1'b1);
    check_all("R9 ACK to 0x01");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule